// File: doc/BRIEF.md
# Asynchronous Bytewide SRAM Cycle Controller

This block sits between a synchronous host and a 32K x 8 asynchronous static memory. The memory has 15 address lines and 8 data lines. The host hands over one read or write at a time through a valid/ready handshake. The controller turns each request into an ordered sequence of active-low chip-enable, output-enable and write-enable strobes. It also presents a registered address and drives or samples the byte-wide data bus. The pad tri-state is modelled as a separate drive-enable output next to split in and out data buses.

All timing is expressed as clock cycle counts:

- The read wait comes from the memory access time and the clock period: the access time divided by the clock period, rounded up, plus one cycle for synchronization.
- The address setup before a write, the write-window width and the write-enable recovery interval are parameters.

A power supervisor can raise a write-inhibit input. Any request accepted while it is high completes at once with an error flag and causes no strobe activity. Consecutive reads keep the chip selected and move only the address. Each new address gets the full access wait.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset all three strobes are high, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: For a read, CE and OE fall together with the new address while WE stays high. Read data is captured `ACC_CYC` clock edges later, where `ACC_CYC` = ceil(`TACC_PS`/`CLK_PS`) + 1, which is 11 at the defaults. The data is returned on `rsp_rdata` with a one-cycle `rsp_valid` and `rsp_error` = 0.
- R3: For a write, the address is presented with all strobes high for at least `SETUP_CYC` cycles. CE and WE then fall on the same edge, and both stay low for exactly `PULSE_CYC` cycles. The address does not change while both are low.
- R4: OE is high whenever WE is low, and it is high during the cycle before a write window opens.
- R5: `mem_dq_oe` is 1 only while the write window is open and for one hold cycle after it closes. It is never 1 while OE is low.
- R6: After a write window closes, no strobe falls earlier than `REC_CYC` + 2 clock edges after WE rises.
- R7: A request accepted while `wr_inhibit` is 1 answers with `rsp_valid` and `rsp_error` = 1 on the next edge. It causes no CE, OE or WE activity, and the memory contents are unchanged.
- R8: A read accepted in the idle cycle right after a read response keeps CE and OE low. Only the address changes, and the full `ACC_CYC` wait applies again.
- R9: `req_ready` is 1 only when no access is in progress, and it is never 1 while WE is low or the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion was refused by write-inhibit |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| wr_inhibit | input | 1 | Power supervisor write-inhibit |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data returned from the memory pads |

## Verification
The hardest case to reach from the ports is the chained read. The follow-on read must already be waiting in the single idle cycle that comes after a read response, or the chip select rises. The driver therefore keeps `req_valid` high and loads the next request on the falling edge right after each acceptance. The bench then counts chip-enable edges across the chain.

The behavioural memory model returns a poison byte until 100 ns have passed since the last address or strobe change. A read sampled even one cycle early shows up as a data mismatch. A write followed at once by a read shows the recovery spacing. An inhibited write followed by a read-back shows that the memory was left untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_REC
  } ctrl_state_e;

  // Read wait: access time rounded up to whole clocks plus one sync cycle
  function automatic int unsigned read_wait_cycles(input int unsigned tacc_ps,
                                                   input int unsigned clk_ps);
    return (tacc_ps + clk_ps - 1) / clk_ps + 1;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..v
  function automatic int unsigned cnt_width(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  // Once expired the timer stays expired until reloaded (supports R2/R3/R6 intervals)
  p_timer_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

endmodule

// File: rtl/sram_bus_datapath.sv
module sram_bus_datapath #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (addr_load) begin
      mem_addr <= req_addr;
      dq_out   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (rd_capture) begin
      rsp_rdata <= dq_in;
    end
  end

  // Returned data only moves on a capture (R2)
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_capture |=> $stable(rsp_rdata));

endmodule

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned REC_CYC   = 2,
  parameter int unsigned ACC_CYC   = 11,
  parameter int unsigned CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             wr_inhibit,
  input  logic             tmr_done,
  output logic             req_ready,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             rsp_valid,
  output logic             rsp_error,
  output logic             addr_load,
  output logic             rd_capture
);
  ctrl_state_e state_q;
  logic        accept;
  logic        accept_inh;
  logic        rd_chain;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign accept_inh = accept && wr_inhibit;
  assign addr_load  = accept && !wr_inhibit;
  assign rd_capture = (state_q == ST_RD_ACC) && tmr_done;
  assign rd_chain   = (state_q == ST_IDLE) && !ce_n;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (addr_load) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(ACC_CYC - 1);
    end else if (state_q == ST_WR_SETUP && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(PULSE_CYC - 1);
    end else if (state_q == ST_WR_HOLD) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(REC_CYC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_inh) begin
            rsp_valid <= 1'b1;
            rsp_error <= 1'b1;
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
          end else if (accept && !req_write) begin
            ce_n    <= 1'b0;
            oe_n    <= 1'b0;
            state_q <= ST_RD_ACC;
          end else if (accept) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            state_q <= ST_WR_SETUP;
          end else begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
          end
        end
        ST_RD_ACC: begin
          if (tmr_done) begin
            rsp_valid <= 1'b1;
            rsp_error <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        ST_WR_SETUP: begin
          if (tmr_done) begin
            ce_n    <= 1'b0;
            we_n    <= 1'b0;
            dq_oe   <= 1'b1;
            state_q <= ST_WR_PULSE;
          end
        end
        ST_WR_PULSE: begin
          if (tmr_done) begin
            ce_n    <= 1'b1;
            we_n    <= 1'b1;
            state_q <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          dq_oe   <= 1'b0;
          state_q <= ST_WR_REC;
        end
        ST_WR_REC: begin
          if (tmr_done) begin
            rsp_valid <= 1'b1;
            rsp_error <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // OE only with CE, never with WE (R2)
  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && we_n));
  // Write enable low implies output enable high (R4)
  p_oe_high_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  // Bus drive begins only as the window opens, never against OE (R5)
  p_drive_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $fell(we_n));
  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  // Inhibited request: immediate error completion, strobes quiet (R7)
  p_inhibit_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_inh |=> (rsp_valid && rsp_error && ce_n && oe_n && we_n));
  // Chained read keeps chip selected (R8)
  p_chain_keeps_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_chain && addr_load && !req_write) |=> (!ce_n && !oe_n));
  // Ready never offered mid-write (R9)
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (we_n && !dq_oe));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned TACC_PS   = 100000,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned PULSE_CYC = 8,
  parameter int unsigned REC_CYC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              wr_inhibit,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned ACC_CYC = read_wait_cycles(TACC_PS, CLK_PS);
  localparam int unsigned CNT_MAX = max_of(max_of(ACC_CYC, PULSE_CYC), max_of(SETUP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = cnt_width(CNT_MAX);
  localparam int unsigned REC_LIM = REC_CYC + 2;
  localparam int unsigned RCNT_W  = cnt_width(REC_LIM);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             addr_load;
  logic             rd_capture;
  logic             win_open;

  sram_interval_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_strobe_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .REC_CYC   (REC_CYC),
    .ACC_CYC   (ACC_CYC),
    .CNT_W     (CNT_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .wr_inhibit (wr_inhibit),
    .tmr_done   (tmr_done),
    .req_ready  (req_ready),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .ce_n       (mem_ce_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_error  (rsp_error),
    .addr_load  (addr_load),
    .rd_capture (rd_capture)
  );

  sram_bus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_load  (addr_load),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_capture (rd_capture),
    .dq_in      (mem_dq_in),
    .mem_addr   (mem_addr),
    .dq_out     (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

  assign win_open = !mem_ce_n && !mem_we_n;

  // Cycles WE has been high since the last window, saturating
  logic [RCNT_W-1:0] we_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_hi_cnt <= RCNT_W'(REC_LIM);
    end else if (!mem_we_n) begin
      we_hi_cnt <= '0;
    end else if (we_hi_cnt != RCNT_W'(REC_LIM)) begin
      we_hi_cnt <= we_hi_cnt + 1'b1;
    end
  end

  // Address frozen while the write window is open (R3)
  p_window_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> $stable(mem_addr));
  // Recovery spacing before the chip is selected again (R6)
  p_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (we_hi_cnt >= RCNT_W'(REC_LIM)));

endmodule

// File: tb/sram_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_tb_top;
  localparam int unsigned SETUP_CYC = 1;
  localparam int unsigned PULSE_CYC = 8;
  localparam int unsigned REC_CYC   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_error;
  logic [7:0]  rsp_rdata;
  logic        wr_inhibit = 1'b0;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sram_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .wr_inhibit(wr_inhibit), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory: 100 ns access ----------------
  logic [7:0] mem_arr [int];
  time        t_chg = 0;

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem_arr.exists(int'(a)) ? mem_arr[int'(a)] : 8'h00;
  endfunction

  always @(mem_addr or mem_ce_n or mem_oe_n) t_chg = $time;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n && (($time - t_chg) >= 100))
      mem_dq_in <= mem_rd(mem_addr);
    else
      mem_dq_in <= 8'hEE;
  end

  // ---------------- protocol monitor ----------------
  bit          prev_win = 0, prev_we = 1, prev_ce = 1, prev_oe = 1;
  int          since_we = 1000, addr_age = 1000, win_len = 0;
  int          ce_falls = 0, ce_rises = 0;
  logic [14:0] prev_addr = '0, win_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit win;
      win = !mem_ce_n && !mem_we_n;
      if (mem_addr != prev_addr) addr_age = 0;
      else if (addr_age < 1000) addr_age++;
      if (mem_we_n && !prev_we) since_we = 1;
      else if (mem_we_n && since_we < 1000) since_we++;
      if (win && !prev_win) begin
        check(addr_age >= SETUP_CYC, "R3 setup", addr_age, SETUP_CYC);
        check(prev_oe && mem_oe_n, "R4 oe before window", mem_oe_n, 1);
        win_addr = mem_addr;
        win_len  = 0;
      end
      if (win) begin
        win_len++;
        if (mem_addr != win_addr) check(0, "R3 addr moved", mem_addr, win_addr);
        if (!mem_oe_n) check(0, "R4 oe low in window", 0, 1);
      end
      if (!win && prev_win) begin
        check(win_len == PULSE_CYC, "R3 window length", win_len, PULSE_CYC);
        check(mem_dq_oe == 1'b1, "R5 hold cycle", mem_dq_oe, 1);
        mem_arr[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : 8'hBD;
      end
      if (mem_dq_oe && !(win || prev_win)) check(0, "R5 drive outside window", 1, 0);
      if (mem_dq_oe && !mem_oe_n) check(0, "R5 contention", 1, 0);
      if (prev_ce && !mem_ce_n) begin
        ce_falls++;
        check(since_we >= REC_CYC + 3, "R6 recovery", since_we, REC_CYC + 3);
      end
      if (!prev_ce && mem_ce_n) ce_rises++;
      if (req_ready && (!mem_we_n || mem_dq_oe)) check(0, "R9 ready mid-write", 1, 0);
      prev_win = win; prev_we = mem_we_n; prev_ce = mem_ce_n;
      prev_oe = mem_oe_n; prev_addr = mem_addr;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit         err;
    bit         has_data;
    logic [7:0] data;
    string      req;
  } exp_t;
  exp_t       exp_q[$];
  logic [7:0] shadow [int];

  function automatic logic [7:0] shadow_rd(input logic [14:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_error == e.err, {e.req, " error flag"}, rsp_error, e.err);
        if (e.has_data) check(rsp_rdata == e.data, {e.req, " read data"}, rsp_rdata, e.data);
      end
    end
  end

  task automatic send(input bit wr, input logic [14:0] a, input logic [7:0] d, input string req);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    e.req = req; e.err = wr_inhibit; e.has_data = 1'b0; e.data = 8'h00;
    if (!wr_inhibit) begin
      if (wr) shadow[int'(a)] = d;
      else begin e.has_data = 1'b1; e.data = shadow_rd(a); end
    end
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0, r0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    check(mem_dq_oe == 1'b0, "R1 dq_oe", mem_dq_oe, 0);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

    // R3 writes at corner addresses, R2 reads back
    send(1, 15'h0000, 8'h11, "R3");
    send(1, 15'h7FFF, 8'hA5, "R3");
    send(1, 15'h1234, 8'h3C, "R3");
    drain();
    send(0, 15'h7FFF, 8'h00, "R2");
    send(0, 15'h0000, 8'h00, "R2");
    send(0, 15'h1234, 8'h00, "R2");
    send(0, 15'h4444, 8'h00, "R2");
    drain();

    // Pattern sweep
    for (int i = 0; i < 8; i++)
      send(1, 15'((i * 16'h0811) & 16'h7FFF), 8'(i * 37 + 5), "R3");
    drain();
    for (int i = 7; i >= 0; i--)
      send(0, 15'((i * 16'h0811) & 16'h7FFF), 8'h00, "R2");
    drain();

    // R6 write immediately followed by read of same byte
    send(1, 15'h0100, 8'h77, "R6");
    send(0, 15'h0100, 8'h00, "R6");
    send(1, 15'h0101, 8'h88, "R6");
    send(1, 15'h0102, 8'h99, "R6");
    send(0, 15'h0101, 8'h00, "R6");
    drain();

    // R8 chained reads: CE falls once and rises once
    r0 = ce_rises; f0 = ce_falls;
    send(0, 15'h0100, 8'h00, "R8");
    send(0, 15'h0101, 8'h00, "R8");
    send(0, 15'h0102, 8'h00, "R8");
    drain();
    check(ce_falls - f0 == 1, "R8 ce falls", ce_falls - f0, 1);
    check(ce_rises - r0 == 1, "R8 ce rises", ce_rises - r0, 1);

    // R7 write-inhibit
    @(negedge clk) wr_inhibit = 1'b1;
    f0 = ce_falls;
    send(1, 15'h0000, 8'h5A, "R7");
    send(0, 15'h7FFF, 8'h00, "R7");
    drain();
    check(ce_falls == f0, "R7 no strobe", ce_falls - f0, 0);
    @(negedge clk) wr_inhibit = 1'b0;
    send(0, 15'h0000, 8'h00, "R7");
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule